// File: doc/BRIEF.md
# YUV to RGB Color Space Converter

This block turns a stream of 8-bit luma and chroma samples into 8-bit red, green and blue pixels. A programmable fixed-point matrix does the conversion. Each output channel is the clamped luma term, times a shared luma gain, plus two chroma products that belong to that channel. The full sum is then rounded and clamped to 0..255. Eight 16-bit coefficient registers hold the matrix. Each register carries its own fixed-point field, justified to bit 0.

Software writes coefficients into a shadow bank. They reach the datapath only when a commit strobe copies the whole bank across in one cycle, so no pixel is ever converted with a mix of old and new values. Samples enter and leave through valid/ready handshakes. The datapath is a three-register pipeline that stalls as one unit when the output is not ready.

Top module: `yuv2rgb_csc`

## Requirements
- R1: Each channel is computed as clamp(round((G*Ys + Ku*Uc + Kv*Vc) / 256)), where rounding adds 128 before an arithmetic shift right by 8 and the clamp limits the result to 0..255. The chroma pairs are (Ku,Kv) = (sel 2, sel 3) for red, (sel 4, sel 5) for green and (sel 6, sel 7) for blue.
- R2: Ys = in_y + O is clamped to 0..255 before the gain is applied. O is the sel 0 register, read as an 8-bit two's complement integer in bits 7:0.
- R3: The gain G is the sel 1 register, read as an unsigned value in bits 9:0 with 8 fraction bits (0x100 = 1.0).
- R4: Sel 2, 3, 6 and 7 are signed fields in bits 10:0 with 8 fraction bits. Sel 4 and 5 are signed fields in bits 9:0 with 8 fraction bits. Register bits above a field's width do not affect the result.
- R5: The chroma inputs are centred before multiplication: Uc = in_u - 128 and Vc = in_v - 128.
- R6: A write with cfg_we high stores cfg_wdata into the shadow register picked by cfg_sel (0..7). Select codes 8..15 change no register.
- R7: Shadow writes do not change the conversion until cfg_commit is high at a clock edge, which copies all eight shadow registers to the active bank. Samples accepted at or before that edge use the old bank.
- R8: After reset the active and shadow banks hold O = 0, G = 0x100 and all chroma coefficients 0, so R = G = B = in_y. out_valid is low after reset.
- R9: With out_ready held high, a sample accepted at clock edge E appears on the outputs with out_valid high after edge E+2.
- R10: While out_valid is high and out_ready is low, in_ready is low and the outputs hold their values. Every accepted sample is delivered exactly once, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Shadow register write enable |
| cfg_sel | input | 4 | Shadow register select |
| cfg_wdata | input | 16 | Shadow register write data |
| cfg_commit | input | 1 | Copy the shadow bank to the active bank |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted when high with in_valid |
| in_y | input | 8 | Luma sample |
| in_u | input | 8 | Blue-difference chroma sample |
| in_v | input | 8 | Red-difference chroma sample |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream ready |
| out_r | output | 8 | Red |
| out_g | output | 8 | Green |
| out_b | output | 8 | Blue |

## Verification
The bench tests the clamp on the luma sum with a large positive offset and a small gain, where a design that skips that clamp returns about 163 instead of 128. It also tests the half-LSB case at a gain of 0.5, where truncation yields 0 and 1 instead of 1 and 2. Both clamps on the final sum are driven at their limits, and so are coefficients with junk in the unused high bits. Wrong sign extension or a missing mask shows up there as wildly wrong colours. Shadow writes without a commit, a commit while samples are still in flight, and an out-of-range select that aliases onto the gain register all catch a bank that leaks early or decodes too few select bits. A long, irregular backpressure pattern catches dropped or repeated pixels and outputs that move while stalled.

// File: rtl/csc_pkg.sv
package csc_pkg;

  localparam int PIX_W    = 8;
  localparam int CREG_W   = 16;
  localparam int NUM_CREG = 8;
  localparam int SEL_W    = 4;
  localparam int CTR_W    = PIX_W + 2;
  localparam int PROD_W   = 20;
  localparam int LUM_W    = 19;
  localparam int SUM_W    = 22;
  localparam int PIPE_STAGES = 3;
  localparam int FRAC_W   = 8;
  localparam int PIX_MAX  = (1 << PIX_W) - 1;

  // register slots
  localparam int IDX_OFS  = 0;
  localparam int IDX_GAIN = 1;

  typedef logic [CREG_W-1:0] creg_t;
  typedef logic signed [CREG_W-1:0] coef_t;
  typedef logic signed [CTR_W-1:0] ctr_t;

  function automatic int ku_slot(input int ch);
    return 2 + 2 * ch;
  endfunction

  function automatic int kv_slot(input int ch);
    return 3 + 2 * ch;
  endfunction

  function automatic int field_width(input int idx);
    if (idx == IDX_OFS) return 8;
    if (idx == IDX_GAIN || idx == 4 || idx == 5) return 10;
    return 11;
  endfunction

  function automatic bit field_signed(input int idx);
    return idx != IDX_GAIN;
  endfunction

  function automatic creg_t reset_value(input int idx);
    return (idx == IDX_GAIN) ? creg_t'(1 << FRAC_W) : '0;
  endfunction

  // Extract a field from its register and extend it to the full width
  function automatic coef_t decode_coef(input int idx, input creg_t raw);
    int    w;
    creg_t msk;
    creg_t f;
    w   = field_width(idx);
    msk = (creg_t'(1) << w) - creg_t'(1);
    f   = raw & msk;
    if (field_signed(idx) && f[w-1]) f = f | ~msk;
    return signed'(f);
  endfunction

  function automatic ctr_t center_chroma(input logic [PIX_W-1:0] x);
    return signed'({2'b00, x}) - ctr_t'(128);
  endfunction

  function automatic logic [PIX_W-1:0] luma_clamp(input logic [PIX_W-1:0] y,
                                                  input coef_t ofs);
    logic signed [CREG_W+1:0] s;
    s = (CREG_W+2)'(signed'({1'b0, y})) + (CREG_W+2)'(ofs);
    if (s < 0) return '0;
    if (s > PIX_MAX) return PIX_W'(PIX_MAX);
    return s[PIX_W-1:0];
  endfunction

  function automatic logic [PIX_W-1:0] round_clamp(input logic signed [SUM_W-1:0] sum);
    logic signed [SUM_W-1:0] t;
    t = (sum + SUM_W'(1 << (FRAC_W - 1))) >>> FRAC_W;
    if (t < 0) return '0;
    if (t > PIX_MAX) return PIX_W'(PIX_MAX);
    return t[PIX_W-1:0];
  endfunction

endpackage

// File: rtl/csc_coef_bank.sv
module csc_coef_bank
  import csc_pkg::*;
#(
  parameter int NREG = NUM_CREG,
  parameter int SW   = SEL_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [SW-1:0]              wr_sel,
  input  logic [CREG_W-1:0]          wr_data,
  input  logic                       commit,
  output logic [NREG-1:0][CREG_W-1:0] active
);

  logic [NREG-1:0][CREG_W-1:0] shadow;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic hit;
    assign hit = wr_en && (wr_sel == SW'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shadow[i] <= reset_value(i);
        active[i] <= reset_value(i);
      end else begin
        if (hit)    shadow[i] <= wr_data;
        if (commit) active[i] <= shadow[i];
      end
    end
  end

endmodule

// File: rtl/csc_pipe_ctrl.sv
module csc_pipe_ctrl #(
  parameter int STAGES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  output logic adv,
  output logic in_ready,
  output logic out_valid
);

  logic [STAGES-1:0] vld;

  assign adv       = !vld[STAGES-1] || out_ready;
  assign in_ready  = adv;
  assign out_valid = vld[STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n)   vld <= '0;
    else if (adv) vld <= {vld[STAGES-2:0], in_valid};
  end

endmodule

// File: rtl/csc_luma.sv
module csc_luma
  import csc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic [PIX_W-1:0]  y,
  input  creg_t             ofs_raw,
  input  creg_t             gain_raw,
  output logic [LUM_W-1:0]  lum
);

  logic [PIX_W-1:0]  ysat_q;
  coef_t             gain_q;

  // stage 1: clamp luma sum, capture gain with the sample
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ysat_q <= '0;
      gain_q <= '0;
    end else if (adv) begin
      ysat_q <= luma_clamp(y, decode_coef(IDX_OFS, ofs_raw));
      gain_q <= decode_coef(IDX_GAIN, gain_raw);
    end
  end

  // product consumed by every channel's stage 2
  assign lum = LUM_W'(unsigned'(gain_q)) * LUM_W'(ysat_q);

endmodule

// File: rtl/csc_chan.sv
module csc_chan
  import csc_pkg::*;
#(
  parameter int KU_IDX = 2,
  parameter int KV_IDX = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  ctr_t              uc,
  input  ctr_t              vc,
  input  creg_t             ku_raw,
  input  creg_t             kv_raw,
  input  logic [LUM_W-1:0]  lum,
  output logic [PIX_W-1:0]  pix
);

  logic signed [PROD_W-1:0] pu_d, pv_d, pu_q, pv_q;
  logic signed [SUM_W-1:0]  sum_q;

  assign pu_d = PROD_W'(decode_coef(KU_IDX, ku_raw)) * PROD_W'(uc);
  assign pv_d = PROD_W'(decode_coef(KV_IDX, kv_raw)) * PROD_W'(vc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pu_q  <= '0;
      pv_q  <= '0;
      sum_q <= '0;
      pix   <= '0;
    end else if (adv) begin
      // stage 1: chroma products
      pu_q  <= pu_d;
      pv_q  <= pv_d;
      // stage 2: full sum
      sum_q <= SUM_W'(signed'({1'b0, lum})) + SUM_W'(pu_q) + SUM_W'(pv_q);
      // stage 3: round and clamp
      pix   <= round_clamp(sum_q);
    end
  end

endmodule

// File: rtl/yuv2rgb_csc.sv
module yuv2rgb_csc
  import csc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [3:0]       cfg_sel,
  input  logic [15:0]      cfg_wdata,
  input  logic             cfg_commit,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_y,
  input  logic [7:0]       in_u,
  input  logic [7:0]       in_v,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_r,
  output logic [7:0]       out_g,
  output logic [7:0]       out_b
);

  logic [NUM_CREG-1:0][CREG_W-1:0] coef_act;
  logic [NUM_CREG*CREG_W-1:0]      coef_act_flat;
  logic                            pipe_adv;
  logic [LUM_W-1:0]                lum_s2;
  ctr_t                            uc, vc;
  logic [2:0][PIX_W-1:0]           pix;

  assign coef_act_flat = coef_act;

  csc_coef_bank #(.NREG(NUM_CREG), .SW(SEL_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_sel  (cfg_sel),
    .wr_data (cfg_wdata),
    .commit  (cfg_commit),
    .active  (coef_act)
  );

  csc_pipe_ctrl #(.STAGES(PIPE_STAGES)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .adv       (pipe_adv),
    .in_ready  (in_ready),
    .out_valid (out_valid)
  );

  assign uc = center_chroma(in_u);
  assign vc = center_chroma(in_v);

  csc_luma u_luma (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (pipe_adv),
    .y        (in_y),
    .ofs_raw  (coef_act[IDX_OFS]),
    .gain_raw (coef_act[IDX_GAIN]),
    .lum      (lum_s2)
  );

  for (genvar ch = 0; ch < 3; ch++) begin : g_ch
    csc_chan #(.KU_IDX(ku_slot(ch)), .KV_IDX(kv_slot(ch))) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv    (pipe_adv),
      .uc     (uc),
      .vc     (vc),
      .ku_raw (coef_act[ku_slot(ch)]),
      .kv_raw (coef_act[kv_slot(ch)]),
      .lum    (lum_s2),
      .pix    (pix[ch])
    );
  end

  assign out_r = pix[0];
  assign out_g = pix[1];
  assign out_b = pix[2];

endmodule

// File: rtl/csc_chk.sv
module csc_chk #(
  parameter int BANK_W = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [23:0]       out_rgb,
  input logic              cfg_commit,
  input logic [BANK_W-1:0] bank
);

  logic       in_fire, out_fire;
  logic [2:0] occ;

  assign in_fire  = in_valid && in_ready;
  assign out_fire = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) occ <= '0;
    else        occ <= occ + 3'(in_fire) - 3'(out_fire);
  end

  // R8
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !out_valid);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_rgb));

  // R10
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R10
  no_phantom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> occ != 3'd0);

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= 3'd3);

  // R7
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_commit |=> $stable(bank));

endmodule

bind yuv2rgb_csc csc_chk #(.BANK_W(csc_pkg::NUM_CREG * csc_pkg::CREG_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_rgb    ({out_r, out_g, out_b}),
  .cfg_commit (cfg_commit),
  .bank       (coef_act_flat)
);

// File: tb/yuv2rgb_csc_tb.sv
`timescale 1ns/1ps
module yuv2rgb_csc_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic        cfg_commit = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_y = '0, in_u = '0, in_v = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_r, out_g, out_b;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  bit bp_mode = 0;
  int bp_cnt = 0;
  int n_rx = 0;

  int mdl_sh[8];
  int mdl_ac[8];
  int expq[$];
  string tagq[$];

  bit          stall_seen = 0;
  logic [23:0] held = '0;

  always #4 clk = ~clk;

  yuv2rgb_csc dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_commit(cfg_commit), .in_valid(in_valid),
    .in_ready(in_ready), .in_y(in_y), .in_u(in_u), .in_v(in_v),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // independent reference model
  function automatic int fdec(input int idx, input int raw);
    int w;
    int f;
    w = (idx == 0) ? 8 : ((idx == 1 || idx == 4 || idx == 5) ? 10 : 11);
    f = raw & ((1 << w) - 1);
    if (idx != 1 && f >= (1 << (w - 1))) f = f - (1 << w);
    return f;
  endfunction

  function automatic int clamp8(input int x);
    return (x < 0) ? 0 : ((x > 255) ? 255 : x);
  endfunction

  function automatic int model(input int y, input int u, input int v);
    int yl, lum, res;
    yl  = clamp8(y + fdec(0, mdl_ac[0]));
    lum = fdec(1, mdl_ac[1]) * yl;
    res = 0;
    for (int ch = 0; ch < 3; ch++) begin
      int s;
      s = lum + fdec(2 + 2*ch, mdl_ac[2 + 2*ch]) * (u - 128)
              + fdec(3 + 2*ch, mdl_ac[3 + 2*ch]) * (v - 128);
      res = (res << 8) | clamp8((s + 128) >>> 8);
    end
    return res;
  endfunction

  always @(posedge clk) begin
    #1;
    bp_cnt++;
    out_ready = !bp_mode || ((bp_cnt % 3 != 1) && (bp_cnt % 11 > 3));
  end

  // output monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_seen)
        chk(out_valid && ({out_r, out_g, out_b} == held), "R10 stall hold",
            int'({out_r, out_g, out_b}), int'(held));
      stall_seen = out_valid && !out_ready;
      held = {out_r, out_g, out_b};
      if (out_valid && out_ready) begin
        n_rx++;
        if (expq.size() == 0) chk(0, "R10 extra output", int'(held), 0);
        else begin
          int e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          chk(int'({out_r, out_g, out_b}) == e, t, int'({out_r, out_g, out_b}), e);
        end
      end
    end
  end

  task automatic cfg_write(input int sel, input int data);
    @(posedge clk); #1;
    cfg_we = 1; cfg_sel = 4'(sel); cfg_wdata = 16'(data);
    @(posedge clk); #1;
    cfg_we = 0;
    if (sel < 8) mdl_sh[sel] = data & 16'hFFFF;
  endtask

  task automatic commit();
    @(posedge clk); #1;
    cfg_commit = 1;
    @(posedge clk); #1;
    cfg_commit = 0;
    for (int i = 0; i < 8; i++) mdl_ac[i] = mdl_sh[i];
  endtask

  task automatic send(input int y, input int u, input int v, input string tag);
    @(posedge clk); #1;
    in_valid = 1; in_y = 8'(y); in_u = 8'(u); in_v = 8'(v);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    expq.push_back(model(y, u, v));
    tagq.push_back(tag);
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < 400 && expq.size() != 0; i++) @(posedge clk);
    repeat (4) @(posedge clk);
    chk(expq.size() == 0, "R10 all delivered", expq.size(), 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(out_valid == 0, "R8 out_valid after reset", out_valid, 0);
    chk(in_ready == 1, "R10 ready when empty", in_ready, 1);
    send(0, 0, 255, "R8 identity y=0");
    send(77, 10, 200, "R8 identity y=77");
    send(255, 128, 0, "R8 identity y=255");
    drain();
  endtask

  task automatic t_matrix();
    cfg_write(0, 16'h00F0);
    cfg_write(1, 16'h012A);
    cfg_write(2, 16'h0000);
    cfg_write(3, 16'h0198);
    cfg_write(4, 16'h039C);
    cfg_write(5, 16'h0330);
    cfg_write(6, 16'h0204);
    cfg_write(7, 16'h0000);
    commit();
    send(16, 128, 128, "R1 matrix black");
    send(235, 128, 128, "R1 matrix white");
    send(81, 90, 240, "R1 R5 matrix red");
    send(145, 54, 34, "R1 R5 matrix green");
    send(41, 240, 110, "R1 R5 matrix blue");
    send(120, 100, 160, "R4 signed 1.8 green terms");
    drain();
  endtask

  task automatic t_sat();
    cfg_write(0, 0); cfg_write(1, 16'h03FF);
    cfg_write(3, 16'h0400); cfg_write(4, 0); cfg_write(5, 0);
    cfg_write(6, 16'h03FF); cfg_write(7, 0);
    commit();
    send(255, 128, 128, "R1 R3 clamp high gain max");
    send(0, 255, 255, "R1 clamp low red neg");
    send(40, 255, 0, "R1 clamp mixed");
    drain();
  endtask

  task automatic t_luma_clamp();
    for (int i = 2; i < 8; i++) cfg_write(i, 0);
    cfg_write(0, 16'h007F); cfg_write(1, 16'h0080);
    commit();
    send(200, 128, 128, "R2 luma clamp high");
    cfg_write(0, 16'h0080);
    commit();
    send(50, 128, 128, "R2 luma clamp low");
    send(200, 128, 128, "R2 negative offset");
    drain();
  endtask

  task automatic t_round();
    cfg_write(0, 0); cfg_write(1, 16'h0080);
    commit();
    send(1, 128, 128, "R1 round half up 0.5");
    send(3, 128, 128, "R1 round half up 1.5");
    send(254, 128, 128, "R1 round 127");
    drain();
  endtask

  task automatic t_hibits();
    cfg_write(0, 16'hFF00);
    cfg_write(1, 16'hFD00);
    cfg_write(3, 16'hF880);
    cfg_write(4, 16'hFC40);
    cfg_write(6, 16'hF940);
    commit();
    send(100, 180, 60, "R4 R2 R3 high bits ignored a");
    send(30, 20, 230, "R4 high bits ignored b");
    drain();
  endtask

  task automatic t_badsel();
    cfg_write(9, 16'h0000);
    cfg_write(15, 16'hFFFF);
    commit();
    send(100, 150, 90, "R6 sel 9 no effect");
    send(200, 40, 220, "R6 sel 15 no effect");
    drain();
  endtask

  task automatic t_commit();
    cfg_write(1, 16'h0040);
    cfg_write(3, 16'h0100);
    send(100, 128, 200, "R7 shadow not yet active");
    drain();
    send(120, 30, 220, "R7 in flight old bank a");
    send(60, 200, 10, "R7 in flight old bank b");
    commit();
    send(120, 30, 220, "R7 after commit");
    drain();
  endtask

  task automatic t_latency();
    send(90, 128, 128, "R9 latency value");
    @(negedge clk);
    chk(out_valid == 0, "R9 not valid after E", out_valid, 0);
    @(negedge clk);
    chk(out_valid == 0, "R9 not valid after E+1", out_valid, 0);
    @(negedge clk);
    chk(out_valid == 1, "R9 valid after E+2", out_valid, 1);
    drain();
  endtask

  task automatic t_backpressure();
    int base;
    base = n_rx;
    bp_mode = 1;
    for (int i = 0; i < 40; i++) send((i * 37) & 255, (i * 91) & 255, (i * 53 + 7) & 255, "R10 backpressure order");
    drain();
    bp_mode = 0;
    chk(n_rx - base == 40, "R10 count delivered", n_rx - base, 40);
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      mdl_sh[i] = (i == 1) ? 256 : 0;
      mdl_ac[i] = mdl_sh[i];
    end
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_matrix();
    t_sat();
    t_luma_clamp();
    t_round();
    t_hibits();
    t_badsel();
    t_commit();
    t_latency();
    t_backpressure();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      summary();
      $finish;
    end
  end

endmodule